// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block is a byte-addressed memory that sits on a two-wire open-drain bus as a target. A fast system clock samples the serial clock and data lines. The block then finds the start and stop conditions and receives each byte bit by bit. It pulls the data line low to acknowledge every byte it accepts. A controller can write one byte or part of a page. It can read from the current address counter, or set the counter with a dummy write and then read. Reads can go on for as many bytes as the controller wants.

The storage size is set by `MEM_BYTES`, a power of two from 128 to 2048. Four things follow from that size:
- the word-address width,
- the page size (8 bytes up to 256, 16 above),
- how many address bits travel in the device byte,
- how many of the three chip-select pins are compared.

When the write-protect input is high, the array is frozen. After a write that changed the array, the target counts a fixed busy period and does not answer its device address until the period ends. The open-drain output is `sda_oe`: a 1 pulls the line low.

Top module: `twi_mem_target`

## Requirements
- R1: A falling data line while the clock line is high is a start condition. A start begins a new transfer from any state. Clock and data activity before the first start is never acknowledged.
- R2: A rising data line while the clock line is high is a stop condition. A stop returns the target to idle with the data line released. After reset the data line is released.
- R3: The device byte is sent most significant bit first.
  - Bits 7..4 must equal `1010`.
  - Bit 0 is 1 for a read and 0 for a write.
  - Bits 3..1 are compared against `sel_pins[2:0]`, but only at the positions not used for address bits.
  - On a mismatch the target does not acknowledge.
- R4: The target acknowledges each accepted byte by holding the data line low for the ninth clock. It changes the data line only while the clock line is low.
- R5: The word address is clog2(MEM_BYTES) bits wide.
  - The bits above 8 travel in device-byte bits from bit 1 upward; the chip-select pins at those positions are ignored.
  - The low 8 bits come in the byte that follows the device byte.
  - On reads the device-byte address bits are ignored.
- R6: Each received data byte is stored at the address counter. After each byte, the counter's in-page bits increment and wrap inside the page. The page is 8 bytes for MEM_BYTES up to 256 and 16 bytes above that. Writes of fewer bytes than a page are allowed.
- R7: A read returns the byte at the address counter. The counter increments after each byte sent and wraps from the top address to 0. A dummy write of the address followed by a repeated start and a read gives a random read.
- R8: While `wp_i` is high, data bytes are still acknowledged, but the array is unchanged and no busy period starts.
- R9: A stop or repeated start that follows at least one stored data byte starts a busy period of WRITE_CYCLES clocks. During the busy period the device byte is not acknowledged.
- R10: When the controller does not acknowledge a read byte, the target releases the data line and sends nothing more until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| sel_pins | input | 3 | Hard-wired chip-select pins, index 2 is the top pin |
| wp_i | input | 1 | Write protect, high freezes the array |

## Verification
Two conditions are the hardest to reach from the ports. The first is an address counter that wraps from the top of a large array back to 0. That only shows up when the upper address bits travel in the device byte. The second is the device byte being refused while the busy period runs. To reach both, the bench puts a 256-byte instance and a 1024-byte instance on the same bus with different chip-select wiring. It writes the last and first bytes of the larger one, then reads across the top of the array. It also polls each device byte right after a stop, before the busy period ends.

// File: rtl/twi_mem_pkg.sv
`timescale 1ns/1ps
package twi_mem_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RXEND, ST_ACK, ST_TX, ST_MACK
  } link_st_t;

  typedef enum logic [1:0] {
    PH_DEV, PH_ADDR, PH_DATA
  } byte_ph_t;

  function automatic int word_bits(input int bytes);
    return $clog2(bytes);
  endfunction

  function automatic int page_bytes(input int bytes);
    return (bytes <= 256) ? 8 : 16;
  endfunction

  function automatic int upper_bits(input int bytes);
    return ($clog2(bytes) > 8) ? ($clog2(bytes) - 8) : 0;
  endfunction

  // chip-select compare: positions below nhi carry address and are skipped
  function automatic logic sel_match(input logic [2:0] dev_sel,
                                     input logic [2:0] pins,
                                     input int nhi);
    for (int i = 0; i < 3; i++) begin
      if (i >= nhi && dev_sel[i] != pins[i]) return 1'b0;
    end
    return 1'b1;
  endfunction

endpackage

// File: rtl/twi_line_sync.sv
`timescale 1ns/1ps
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [1:0] chain [STAGES];
  logic [1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 2'b11;
    else        chain[0] <= {scl_i, sda_i};
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= 2'b11;
      else        chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 2'b11;
    else        prev <= chain[STAGES-1];
  end

  assign scl_s    = chain[STAGES-1][1];
  assign sda_s    = chain[STAGES-1][0];
  assign scl_rise = scl_s & ~prev[1];
  assign scl_fall = ~scl_s & prev[1];
  assign start_ev = prev[1] & scl_s & prev[0] & ~sda_s;
  assign stop_ev  = prev[1] & scl_s & ~prev[0] & sda_s;
endmodule

// File: rtl/twi_write_timer.sv
`timescale 1ns/1ps
module twi_write_timer #(
  parameter int WRITE_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy
);
  localparam int CW = $clog2(WRITE_CYCLES + 1);
  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             remain <= '0;
    else if (kick)          remain <= CW'(WRITE_CYCLES);
    else if (remain != '0)  remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);

  AST_BUSY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> busy); // R9
endmodule

// File: rtl/twi_mem_array.sv
`timescale 1ns/1ps
module twi_mem_array #(
  parameter int BYTES = 256,
  localparam int AW = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] cells [BYTES];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/twi_mem_target.sv
`timescale 1ns/1ps
module twi_mem_target
  import twi_mem_pkg::*;
#(
  parameter int         MEM_BYTES    = 256,
  parameter int         WRITE_CYCLES = 2000,
  parameter int         SYNC_STAGES  = 2,
  parameter logic [3:0] DEV_CODE     = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] sel_pins,
  input  logic       wp_i
);
  localparam int AW  = word_bits(MEM_BYTES);
  localparam int PG  = page_bytes(MEM_BYTES);
  localparam int PW  = $clog2(PG);
  localparam int NHI = upper_bits(MEM_BYTES);
  localparam logic [2:0] HI_MASK = 3'((1 << NHI) - 1);

  // bus events
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  // address arithmetic
  function automatic logic [AW-1:0] join_addr(input logic [2:0] hi, input logic [7:0] lo);
    logic [10:0] full;
    full = {hi & HI_MASK, lo};
    return full[AW-1:0];
  endfunction

  function automatic logic [AW-1:0] step_in_page(input logic [AW-1:0] a);
    logic [AW-1:0] r;
    r = a;
    r[PW-1:0] = a[PW-1:0] + 1'b1;
    return r;
  endfunction

  function automatic logic [AW-1:0] step_linear(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  // state
  link_st_t      state;
  byte_ph_t      phase;
  logic [2:0]    bitcnt;
  logic [7:0]    rx_sh, tx_sh;
  logic [AW-1:0] addr;
  logic          rd_mode, mack_ok, wrote;
  logic [2:0]    hi_lat;

  // named internal events
  logic          busy, byte_end, dev_ok, mem_we, commit, nack_end;
  logic [7:0]    mem_rd;

  assign byte_end = (state == ST_RXEND) && scl_fall;
  assign dev_ok   = (rx_sh[7:4] == DEV_CODE) && sel_match(rx_sh[3:1], sel_pins, NHI) && !busy;
  assign mem_we   = byte_end && (phase == PH_DATA) && !wp_i;
  assign commit   = (start_ev || stop_ev) && wrote;
  assign nack_end = (state == ST_MACK) && scl_fall && !mack_ok;

  twi_mem_array #(.BYTES(MEM_BYTES)) u_array (
    .clk(clk), .we(mem_we), .waddr(addr), .wdata(rx_sh),
    .raddr(addr), .rdata(mem_rd)
  );

  twi_write_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .kick(commit), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wrote <= 1'b0;
    else if (commit) wrote <= 1'b0;
    else if (mem_we) wrote <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      phase   <= PH_DEV;
      bitcnt  <= '0;
      rx_sh   <= '0;
      tx_sh   <= '1;
      addr    <= '0;
      rd_mode <= 1'b0;
      mack_ok <= 1'b0;
      hi_lat  <= '0;
    end else if (start_ev) begin
      state  <= ST_RX;
      phase  <= PH_DEV;
      bitcnt <= '0;
    end else if (stop_ev) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_RX: if (scl_rise) begin
          rx_sh  <= {rx_sh[6:0], sda_s};
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == 3'd7) state <= ST_RXEND;
        end
        ST_RXEND: if (scl_fall) begin
          unique case (phase)
            PH_DEV: begin
              if (dev_ok) begin
                state   <= ST_ACK;
                rd_mode <= rx_sh[0];
                if (!rx_sh[0]) hi_lat <= rx_sh[3:1];
              end else begin
                state <= ST_IDLE;
              end
            end
            PH_ADDR: begin
              addr  <= join_addr(hi_lat, rx_sh);
              state <= ST_ACK;
            end
            default: begin
              addr  <= step_in_page(addr);
              state <= ST_ACK;
            end
          endcase
        end
        ST_ACK: if (scl_fall) begin
          bitcnt <= '0;
          if (phase == PH_DEV && rd_mode) begin
            state <= ST_TX;
            tx_sh <= mem_rd;
          end else begin
            state <= ST_RX;
            phase <= (phase == PH_DEV) ? PH_ADDR : PH_DATA;
          end
        end
        ST_TX: if (scl_fall) begin
          tx_sh  <= {tx_sh[6:0], 1'b1};
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == 3'd7) begin
            state <= ST_MACK;
            addr  <= step_linear(addr);
          end
        end
        ST_MACK: begin
          if (scl_rise) mack_ok <= !sda_s;
          if (scl_fall) begin
            if (mack_ok) begin
              state  <= ST_TX;
              tx_sh  <= mem_rd;
              bitcnt <= '0;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sda_oe = (state == ST_ACK) || (state == ST_TX && !tx_sh[7]);

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s); // R4
  AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (state == ST_IDLE) && !sda_oe); // R2
  AST_BUSY_NO_DEV_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACK && phase == PH_DEV) |-> !busy); // R9
  AST_RELEASE_AFTER_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    nack_end |=> !sda_oe); // R10
endmodule

// File: tb/sim_twi_mem_target.sv
`timescale 1ns/1ps
module sim_twi_mem_target;
  localparam int T     = 50;
  localparam int WCYC  = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic oe0, oe1;
  wire  sda = sda_m & ~oe0 & ~oe1;

  always #2.5 clk = ~clk;

  twi_mem_target #(.MEM_BYTES(256), .WRITE_CYCLES(WCYC)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe(oe0),
    .sel_pins(3'b000), .wp_i(wp));
  twi_mem_target #(.MEM_BYTES(1024), .WRITE_CYCLES(WCYC)) u1 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe(oe1),
    .sel_pins(3'b110), .wp_i(wp));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_val;
  event       got_ev;

  initial forever begin
    @(got_ev);
    if (exp_q.size() == 0) check("R7 unexpected byte", got_val, 0);
    else check(tag_q.pop_front(), got_val, exp_q.pop_front());
  end

  // bus driver
  task automatic bit_io(input logic b, output logic r);
    sda_m = b; #T; scl = 1'b1; #(2*T); r = sda; scl = 1'b0; #T;
  endtask
  task automatic do_start();
    sda_m = 1'b1; #T; scl = 1'b1; #T; sda_m = 1'b0; #T; scl = 1'b0; #T;
  endtask
  task automatic do_stop();
    sda_m = 1'b0; #T; scl = 1'b1; #T; sda_m = 1'b1; #T;
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(b[i], r);
    bit_io(1'b1, r);
    ack = !r;
  endtask
  task automatic put(input string tag, input logic [7:0] b);
    logic ack;
    send_byte(b, ack);
    check(tag, ack, 1);
  endtask
  task automatic get(input string tag, input logic [7:0] e, input logic more);
    logic r;
    logic [7:0] v = '0;
    exp_q.push_back(e); tag_q.push_back(tag);
    for (int i = 0; i < 8; i++) begin bit_io(1'b1, r); v = {v[6:0], r}; end
    bit_io(!more, r);
    got_val = v; ->got_ev;
  endtask
  task automatic wait_busy();
    #(WCYC * 5 + 500);
  endtask

  // reference models
  logic [7:0] m0 [256];
  function automatic logic [7:0] pg8(input logic [7:0] a);
    return {a[7:3], 3'(a[2:0] + 3'd1)};
  endfunction

  initial begin
    #(150000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic ack, r, all_hi;
    logic [7:0] a;
    #100; rst_n = 1'b1; #100;
    check("R2 reset release", sda, 1);

    // R1: byte clocked without a start is ignored
    scl = 1'b0; #T;
    send_byte(8'hA0, ack);
    check("R1 no start no ack", ack, 0);
    do_stop();

    // R3: wrong chip select
    do_start(); send_byte(8'hA4, ack); check("R3 select mismatch", ack, 0); do_stop();

    // R6 byte write then partial page write with in-page wrap
    do_start(); put("R4 dev ack", 8'hA0); put("R4 addr ack", 8'h08);
    put("R6 data", 8'h5A); m0[8] = 8'h5A;
    put("R6 data", 8'h6B); m0[9] = 8'h6B;
    do_stop();
    do_start(); send_byte(8'hA0, ack); check("R9 busy refuses", ack, 0); do_stop();
    wait_busy();
    do_start(); send_byte(8'hA0, ack); check("R9 ready again", ack, 1); do_stop();

    do_start(); put("R4 dev ack", 8'hA0); put("R4 addr ack", 8'h05);
    a = 8'h05;
    foreach (exp_q[i]) ;
    begin
      logic [7:0] d [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
      for (int i = 0; i < 4; i++) begin put("R6 page data", d[i]); m0[a] = d[i]; a = pg8(a); end
    end
    do_stop(); wait_busy();

    // R7 random read crossing page, then R10 release
    do_start(); put("R7 dummy dev", 8'hA0); put("R7 dummy addr", 8'h05);
    do_start(); put("R7 read dev", 8'hA1);
    get("R7 seq 5", m0[5], 1); get("R7 seq 6", m0[6], 1);
    get("R6 wrapped 7", m0[7], 1); get("R7 seq 8", m0[8], 0);
    all_hi = 1'b1;
    for (int i = 0; i < 9; i++) begin bit_io(1'b1, r); all_hi &= r; end
    check("R10 released after nack", all_hi, 1);
    do_stop();
    check("R6 wrap wrote 0", m0[0], 8'h44);
    do_start(); put("R7 cur dev", 8'hA1); get("R7 current address", m0[9], 0); do_stop();
    do_start(); put("R7 dev", 8'hA0); put("R7 addr", 8'h00);
    do_start(); put("R7 rd", 8'hA1); get("R6 page wrap to 0", 8'h44, 0); do_stop();

    // R8 write protect
    wp = 1'b1;
    do_start(); put("R8 dev ack", 8'hA0); put("R8 addr ack", 8'h08); put("R8 data ack", 8'hFF);
    do_stop();
    do_start(); send_byte(8'hA0, ack); check("R8 no busy", ack, 1); do_stop();
    wp = 1'b0;
    do_start(); put("R8 dev", 8'hA0); put("R8 addr", 8'h08);
    do_start(); put("R8 rd", 8'hA1); get("R8 unchanged", 8'h5A, 0); do_stop();

    // R5 upper address bits in device byte, R7 wrap at top of 1024
    do_start(); put("R5 dev hi=3", 8'hAE); put("R5 addr low", 8'hFF); put("R5 data", 8'hC3); do_stop();
    wait_busy();
    do_start(); put("R5 dev hi=0", 8'hA8); put("R5 addr low", 8'h00); put("R5 data", 8'h3C); do_stop();
    wait_busy();
    do_start(); put("R5 dummy", 8'hAE); put("R5 low", 8'hFF);
    do_start(); put("R5 rd dev", 8'hA9);
    get("R5 top byte", 8'hC3, 1); get("R7 wrap to 0", 8'h3C, 0);
    do_stop();

    #(10 * T);
    check("R2 idle released", sda, 1);
    check("R7 queue drained", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule